// File: doc/BRIEF.md
# Column Burst Engine with Clock Suspend

This block is the column datapath of a synchronous DRAM-style memory. It takes a decoded command with a column address and a burst length. It then steps through a burst of consecutive columns in a small word array, either writing data presented on the input or returning read data on an output bus with an output enable. Read data appears after a selectable latency. Addresses step sequentially and wrap inside a block aligned to the burst length.

A clock-enable input is sampled on every rising edge of one free-running clock. While a burst or its read data is still in flight, a low sample freezes the block on the following edge. On a frozen edge the block ignores commands and write data, does not advance the burst position or the latency pipeline, and keeps the output bus and its enable unchanged. The freeze comes from a registered internal enable, not a gated clock. A low sample while nothing is in flight has no effect.

Top module: `burst_susp_engine`

## Requirements
- R1: While reset is asserted and right after it, `dqOe` is low, `dqOut` is zero and no burst is in progress.
- R2: A READ (`cmd` = 2'b01) on an active edge starts a burst of L = 1, 2, 4 or 8 beats (`blSel` = 0, 1, 2, 3). Beat i reads column (A & ~(L-1)) | ((A+i) & (L-1)), where A is `addr`, and the beats appear on `dqOut` with `dqOe` high on consecutive active edges.
- R3: With `casLat` = 0 the first read beat is on `dqOut` after the 2nd active edge following the READ edge, and with `casLat` = 1 after the 3rd. Frozen edges are not counted.
- R4: A WRITE (`cmd` = 2'b10) stores `wrData` at `addr` on its own edge. Each following active edge stores `wrData` at the next column in the order of R2, until L beats are stored.
- R5: A low `cke` sampled at a rising edge while beats remain or read data is still in flight freezes the next rising edge. Operation resumes on the edge after a high `cke` is sampled.
- R6: Across a frozen edge, `dqOut` and `dqOe` keep their values.
- R7: On a frozen edge, the command and `wrData` are ignored and the burst position does not advance.
- R8: A low `cke` while no beats remain and no read data is in flight freezes nothing, and a command on that edge is accepted.
- R9: A STOP (`cmd` = 2'b11) ends the burst. For a read, the beat due on the STOP edge and all earlier beats still appear, and no further beats follow.
- R10: A WRITE during a read burst drops `dqOe` after the WRITE edge, discards the undelivered read beats and performs the write.
- R11: A READ during a read burst starts the new burst. The old beats due up to and including that edge still appear, and the new beats follow directly after them.
- R12: A READ or STOP during a write burst discards the remaining write beats, including the one due on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock-enable sample input |
| cmd | input | 2 | Decoded command: NOP, READ, WRITE, STOP |
| addr | input | COL_W | Start column of a burst |
| blSel | input | BL_SEL_W | Burst length select, L = 2**blSel |
| casLat | input | 1 | Read latency select: 0 gives 2, 1 gives 3 |
| wrData | input | DATA_W | Write data for the current beat |
| dqOut | output | DATA_W | Read data, zero while not enabled |
| dqOe | output | 1 | Read data valid / output enable |

## Verification
A wrong freeze decision shows on the output bus one edge later. Either read data moves during a cycle when it should hold, or it holds when it should move. Every later beat of the burst is then shifted by one cycle. A burst counter that advances on a frozen edge, or a write accepted while frozen, does not show at once. It surfaces as a wrong word when that column is read back, or as a burst that ends one beat early. Latency errors shift the first beat of every read and are visible on the first read after the fault.

// File: rtl/bse_pkg.sv
package bse_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_STOP  = 2'b11
  } cmd_e;

  // strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic ce;     // this edge is an internal (non-frozen) edge
    logic wrEn;   // store a word on this edge
    logic rdEn;   // launch a read beat on this edge
    logic flush;  // discard every read word in flight
    logic cl3;    // three-cycle read latency selected
  } strobe_t;

endpackage

// File: rtl/bse_ctrl.sv
module bse_ctrl
  import bse_pkg::*;
#(
  parameter int COL_W    = 6,
  parameter int BL_SEL_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cke,
  input  logic [1:0]          cmd,
  input  logic [COL_W-1:0]    addr,
  input  logic [BL_SEL_W-1:0] blSel,
  input  logic                casLat,
  input  logic                pipeBusy,
  output strobe_t             strb,
  output logic [COL_W-1:0]    wrAddr,
  output logic [COL_W-1:0]    rdAddr
);

  // beat index width covers the longest burst, 2**(2**BL_SEL_W - 1) beats
  localparam int IDX_W = (1 << BL_SEL_W) - 1;

  cmd_e             cmdIn;
  logic             holdQ;
  logic             ce;
  logic             busy;
  logic             rdActive;
  logic             wrActive;
  logic             cl3Q;
  logic [COL_W-1:0] baseQ;
  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] lastIdxQ;
  logic [IDX_W-1:0] lastIdxNew;
  logic [COL_W-1:0] lastExt;
  logic [COL_W-1:0] beatAddr;

  assign cmdIn      = cmd_e'(cmd);
  assign ce         = !holdQ;
  assign busy       = rdActive || wrActive || pipeBusy;
  assign lastIdxNew = IDX_W'((1 << blSel) - 1);
  assign lastExt    = COL_W'(lastIdxQ);
  assign beatAddr   = (baseQ & ~lastExt) | ((baseQ + COL_W'(idxQ)) & lastExt);

  // cke is sampled on every edge, frozen or not; a low sample during
  // activity freezes the following edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdQ <= 1'b0;
    else       holdQ <= !cke && busy;
  end

  always_comb begin
    strb.ce    = ce;
    strb.cl3   = cl3Q;
    strb.flush = ce && (cmdIn == CMD_WRITE);
    strb.rdEn  = ce && rdActive && (cmdIn != CMD_WRITE);
    strb.wrEn  = ce && ((cmdIn == CMD_WRITE) || (wrActive && cmdIn == CMD_NOP));
    wrAddr     = (cmdIn == CMD_WRITE) ? addr : beatAddr;
    rdAddr     = beatAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdActive <= 1'b0;
      wrActive <= 1'b0;
      cl3Q     <= 1'b0;
      baseQ    <= '0;
      idxQ     <= '0;
      lastIdxQ <= '0;
    end else if (ce) begin
      unique case (cmdIn)
        CMD_READ: begin
          rdActive <= 1'b1;
          wrActive <= 1'b0;
          baseQ    <= addr;
          lastIdxQ <= lastIdxNew;
          idxQ     <= '0;
          cl3Q     <= casLat;
        end
        CMD_WRITE: begin
          rdActive <= 1'b0;
          wrActive <= (lastIdxNew != '0);
          baseQ    <= addr;
          lastIdxQ <= lastIdxNew;
          idxQ     <= IDX_W'(1);
        end
        CMD_STOP: begin
          rdActive <= 1'b0;
          wrActive <= 1'b0;
        end
        default: begin
          if (rdActive || wrActive) begin
            if (idxQ == lastIdxQ) begin
              rdActive <= 1'b0;
              wrActive <= 1'b0;
            end else begin
              idxQ <= idxQ + IDX_W'(1);
            end
          end
        end
      endcase
    end
  end

  // R7
  freeze_holds_position_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ce |=> ($stable(idxQ) && $stable(rdActive) && $stable(wrActive) && $stable(baseQ)));

  // R8
  idle_no_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> ce);

  // R12
  one_direction_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdActive, wrActive}));

endmodule

// File: rtl/bse_dpath.sv
module bse_dpath
  import bse_pkg::*;
#(
  parameter int COL_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [COL_W-1:0]  wrAddr,
  input  logic [COL_W-1:0]  rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              pipeBusy,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);

  localparam int DEPTH = 1 << COL_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdWord;
  logic              s1V, s2V, dqV;
  logic [DATA_W-1:0] s1D, s2D, dqD;

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrAddr] <= wrData;
  end

  assign rdWord = mem[rdAddr];

  // stage one holds a freshly read word; stage two exists only for
  // the three-cycle latency; the output register taps one of them
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1V <= 1'b0;
      s2V <= 1'b0;
      dqV <= 1'b0;
      s1D <= '0;
      s2D <= '0;
      dqD <= '0;
    end else if (strb.ce) begin
      if (strb.flush) begin
        s1V <= 1'b0;
        s2V <= 1'b0;
        dqV <= 1'b0;
      end else begin
        s1V <= strb.rdEn;
        s1D <= rdWord;
        s2V <= s1V && strb.cl3;
        s2D <= s1D;
        dqV <= strb.cl3 ? s2V : s1V;
        dqD <= strb.cl3 ? s2D : s1D;
      end
    end
  end

  assign pipeBusy = s1V || s2V || dqV;
  assign dqOe     = dqV;
  assign dqOut    = dqV ? dqD : '0;

  // R6
  frozen_bus_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ce |=> ($stable(dqOut) && $stable(dqOe)));

  // R10
  write_drops_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> !dqOe);

  // R2
  no_double_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdEn && strb.wrEn));

endmodule

// File: rtl/burst_susp_engine.sv
module burst_susp_engine
  import bse_pkg::*;
#(
  parameter int COL_W    = 6,
  parameter int DATA_W   = 16,
  parameter int BL_SEL_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cke,
  input  logic [1:0]          cmd,
  input  logic [COL_W-1:0]    addr,
  input  logic [BL_SEL_W-1:0] blSel,
  input  logic                casLat,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   dqOut,
  output logic                dqOe
);

  strobe_t          strb;
  logic [COL_W-1:0] wrAddr;
  logic [COL_W-1:0] rdAddr;
  logic             pipeBusy;

  bse_ctrl #(
    .COL_W    (COL_W),
    .BL_SEL_W (BL_SEL_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cke      (cke),
    .cmd      (cmd),
    .addr     (addr),
    .blSel    (blSel),
    .casLat   (casLat),
    .pipeBusy (pipeBusy),
    .strb     (strb),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr)
  );

  bse_dpath #(
    .COL_W  (COL_W),
    .DATA_W (DATA_W)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .wrData   (wrData),
    .pipeBusy (pipeBusy),
    .dqOut    (dqOut),
    .dqOe     (dqOe)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!dqOe && dqOut == '0));

endmodule

// File: tb/tb_burst_susp_engine.sv
module tb_burst_susp_engine;

  localparam int CLK_PERIOD = 10;
  localparam int COL_W  = 6;
  localparam int DATA_W = 16;
  localparam logic [1:0] NOP = 2'b00, RD = 2'b01, WR = 2'b10, STP = 2'b11;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cke = 1'b1;
  logic [1:0]        cmd = NOP;
  logic [COL_W-1:0]  addr = '0;
  logic [1:0]        blSel = '0;
  logic              casLat = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] dqOut;
  logic              dqOe;

  int nChecks = 0;
  int nFails  = 0;
  string curTag = "R3";

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_susp_engine #(.COL_W(COL_W), .DATA_W(DATA_W), .BL_SEL_W(2)) dut (
    .clk(clk), .rstN(rstN), .cke(cke), .cmd(cmd), .addr(addr),
    .blSel(blSel), .casLat(casLat), .wrData(wrData),
    .dqOut(dqOut), .dqOe(dqOe)
  );

  // ---------------- reference model, written from the requirements ----
  logic [DATA_W-1:0] mMem [1 << COL_W];
  bit                mHold, mLastHeld, busyNow;
  int                rdLeft, wrLeft, rdIdx, wrIdx, mLen;
  logic [COL_W-1:0]  mBase;
  bit                mCl3;
  bit                mDqV, q1V, q2V;
  logic [DATA_W-1:0] mDq, q1D, q2D, rdVal;
  bit                rdGot;

  function automatic logic [COL_W-1:0] colOf(logic [COL_W-1:0] b, int i, int len);
    logic [COL_W-1:0] m;
    m = COL_W'(len - 1);
    return (b & ~m) | (COL_W'(int'(b) + i) & m);
  endfunction

  task automatic modelEdge();
    rdGot = 0;
    if (rdLeft > 0 && cmd != WR) begin
      rdVal = mMem[colOf(mBase, rdIdx, mLen)];
      rdGot = 1; rdIdx++; rdLeft--;
    end
    if (wrLeft > 0) begin
      if (cmd == NOP) begin
        mMem[colOf(mBase, wrIdx, mLen)] = wrData;
        wrIdx++; wrLeft--;
      end else wrLeft = 0;
    end
    mDqV = q1V; mDq = q1D; q1V = q2V; q1D = q2D; q2V = 0;
    if (rdGot) begin
      if (mCl3) begin q2V = 1; q2D = rdVal; end
      else      begin q1V = 1; q1D = rdVal; end
    end
    case (cmd)
      RD: begin
        mLen = 1 << blSel; rdLeft = mLen; rdIdx = 0; mBase = addr;
        mCl3 = casLat; wrLeft = 0;
      end
      WR: begin
        mDqV = 0; q1V = 0; q2V = 0;
        mMem[addr] = wrData;
        mLen = 1 << blSel; wrLeft = mLen - 1; wrIdx = 1; mBase = addr; rdLeft = 0;
      end
      STP: begin rdLeft = 0; wrLeft = 0; end
      default: ;
    endcase
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mHold = 0; mLastHeld = 0; rdLeft = 0; wrLeft = 0; rdIdx = 0; wrIdx = 0;
      mLen = 1; mBase = '0; mCl3 = 0; mDqV = 0; q1V = 0; q2V = 0;
      mDq = '0; q1D = '0; q2D = '0;
    end else begin
      busyNow   = rdLeft > 0 || wrLeft > 0 || mDqV || q1V || q2V;
      mLastHeld = mHold;
      mHold     = !cke && busyNow;
      if (!mLastHeld) modelEdge();
    end
  end

  // ---------------- continuous output comparison ----------------------
  always @(negedge clk) begin
    if (rstN) begin
      nChecks++;
      if (dqOe !== mDqV || (mDqV && dqOut !== mDq)) begin
        nFails++;
        $display("FAIL %s: dqOe/dqOut = %b/%h expected %b/%h at %0t",
                 mLastHeld ? "R6" : curTag, dqOe, dqOut, mDqV, mDq, $time);
      end
    end
  end

  // ---------------- stimulus ------------------------------------------
  task automatic drive(input logic [1:0] c, input logic [COL_W-1:0] a,
                       input logic [1:0] bl, input logic cl, input logic k);
    cmd = c; addr = a; blSel = bl; casLat = cl; cke = k;
    wrData = DATA_W'($urandom);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(NOP, '0, 2'd0, casLat, 1'b1);
  endtask

  task automatic randomRun(input int n, input logic cl);
    for (int i = 0; i < n; i++) begin
      int r;
      logic [1:0] c;
      r = int'($urandom % 100);
      c = (r < 60) ? NOP : (r < 76) ? RD : (r < 90) ? WR : STP;
      drive(c, COL_W'($urandom), 2'($urandom), cl, ($urandom % 4) != 0);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog: run did not end, actual running expected finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    // R1: quiet output while reset is held
    nChecks++;
    if (dqOe !== 1'b0 || dqOut !== '0) begin
      nFails++;
      $display("FAIL R1: dqOe/dqOut = %b/%h expected 0/0000", dqOe, dqOut);
    end
    rstN = 1'b1;
    @(negedge clk);
    nChecks++;
    if (dqOe !== 1'b0) begin
      nFails++;
      $display("FAIL R1: dqOe = %b expected 0 after reset", dqOe);
    end

    // R4: fill the whole array with eight-beat writes
    curTag = "R4";
    for (int b = 0; b < 8; b++) begin
      drive(WR, COL_W'(b * 8), 2'd3, 1'b0, 1'b1);
      for (int j = 0; j < 7; j++) drive(NOP, '0, 2'd0, 1'b0, 1'b1);
    end
    for (int b = 0; b < 8; b++) begin
      drive(RD, COL_W'(b * 8 + 3), 2'd3, 1'b0, 1'b1);
      for (int j = 0; j < 7; j++) drive(NOP, '0, 2'd0, 1'b0, 1'b1);
    end
    idle(6);

    // R2: every burst length from an unaligned start column
    curTag = "R2";
    for (int bl = 0; bl < 4; bl++) begin
      drive(RD, 6'd13, 2'(bl), 1'b0, 1'b1);
      idle(12);
    end

    // R3: three-cycle latency
    curTag = "R3";
    for (int bl = 0; bl < 4; bl++) begin
      drive(RD, 6'd22, 2'(bl), 1'b1, 1'b1);
      idle(12);
    end

    // R5: freezes in the middle of a read, single and repeated
    curTag = "R5";
    drive(RD, 6'd4, 2'd3, 1'b0, 1'b1);
    drive(NOP, '0, 2'd0, 1'b0, 1'b1);
    drive(NOP, '0, 2'd0, 1'b0, 1'b0);
    drive(NOP, '0, 2'd0, 1'b0, 1'b1);
    drive(NOP, '0, 2'd0, 1'b0, 1'b0);
    drive(NOP, '0, 2'd0, 1'b0, 1'b0);
    drive(NOP, '0, 2'd0, 1'b0, 1'b0);
    idle(14);

    // R7: a write offered on a frozen edge must not land
    curTag = "R7";
    drive(RD, 6'd0, 2'd3, 1'b0, 1'b1);
    drive(NOP, '0, 2'd0, 1'b0, 1'b1);
    drive(NOP, '0, 2'd0, 1'b0, 1'b0);
    drive(WR, 6'd40, 2'd0, 1'b0, 1'b1);
    idle(14);
    drive(RD, 6'd40, 2'd0, 1'b0, 1'b1);
    idle(6);

    // R8: low cke while idle leaves commands working
    curTag = "R8";
    drive(WR, 6'd50, 2'd0, 1'b0, 1'b0);
    for (int j = 0; j < 3; j++) drive(NOP, '0, 2'd0, 1'b0, 1'b0);
    drive(RD, 6'd50, 2'd0, 1'b0, 1'b0);
    for (int j = 0; j < 4; j++) drive(NOP, '0, 2'd0, 1'b0, 1'b0);
    idle(8);

    // R9: stop in the middle of a read
    curTag = "R9";
    drive(RD, 6'd16, 2'd3, 1'b0, 1'b1);
    idle(3);
    drive(STP, '0, 2'd0, 1'b0, 1'b1);
    idle(10);

    // R10: write breaks into a read
    curTag = "R10";
    drive(RD, 6'd32, 2'd3, 1'b1, 1'b1);
    idle(2);
    drive(WR, 6'd35, 2'd1, 1'b1, 1'b1);
    idle(4);
    drive(RD, 6'd32, 2'd3, 1'b1, 1'b1);
    idle(14);

    // R11: read replaces a read burst
    curTag = "R11";
    drive(RD, 6'd8, 2'd2, 1'b0, 1'b1);
    idle(2);
    drive(RD, 6'd60, 2'd2, 1'b0, 1'b1);
    idle(10);

    // R12: read and stop break into write bursts
    curTag = "R12";
    drive(WR, 6'd24, 2'd3, 1'b0, 1'b1);
    idle(2);
    drive(RD, 6'd24, 2'd3, 1'b0, 1'b1);
    idle(12);
    drive(WR, 6'd48, 2'd3, 1'b0, 1'b1);
    idle(1);
    drive(STP, '0, 2'd0, 1'b0, 1'b1);
    drive(RD, 6'd48, 2'd3, 1'b0, 1'b1);
    idle(12);

    // mixed traffic with random cke, one latency per run
    curTag = "R3";
    randomRun(4000, 1'b0);
    idle(16);
    curTag = "R5";
    randomRun(4000, 1'b1);
    idle(16);

    finishRun();
  end

endmodule